// File: doc/BRIEF.md
# Dual-Stream Double-Data-Rate SPI Slave Serializer

This block is the slave-side serial front end for a device built from two identical converter cores that share one command stream. During every chip-select frame the master shifts a 16-bit command in on MOSI, most significant bit first. Both cores see the same command. On the return path the block merges two 16-bit result words, one per core, onto a single MISO wire at double data rate. One frame therefore carries 32 result bits back while only 16 SCLK cycles run.

The core A word goes out on the bits the master captures at SCLK falling edges. The core B word goes out on the bits the master captures at SCLK rising edges. The first rising edge of a frame carries a filler bit. The last B bit is presented for capture at the moment chip select returns high. The two result words come from parallel inputs and are taken in once, when chip select falls. Results are pipelined, so the words a frame returns belong to an earlier command.

The port signals CS_n, SCLK and MOSI are assumed to be synchronous to the block clock, which runs several times faster than SCLK. The block registers them once and detects their edges.

Top module: `ddr_spi_slave`

## Requirements
- R1: While chip select is high, MISO is 0 from the first clock edge after chip select rises until the next frame starts.
- R2: The command is shifted in MSB first on SCLK rising edges. When a frame with exactly 16 rising edges ends, `cmd_word` holds the command and `cmd_valid` pulses high for one clock, in the first clock edge after chip select rises.
- R3: At the k-th SCLK falling edge of a frame (k = 1..16), MISO holds bit 16-k of the core A word.
- R4: At the k-th SCLK rising edge (k = 2..16), MISO holds bit 17-k of the core B word, and when chip select rises MISO holds bit 0 of the core B word. The bit at the first rising edge is a don't-care.
- R5: Both response words are captured when chip select falls. A change on `resp_a` or `resp_b` later in the frame has no effect on the bits sent in that frame.
- R6: A frame whose count of SCLK rising edges is not 16 raises `frame_err` for one clock when chip select rises. It does not raise `cmd_valid` and leaves `cmd_word` unchanged.
- R7: After reset, `miso`, `cmd_valid` and `frame_err` are 0 and `cmd_word` is 0.
- R8: Inside a frame, MISO changes only in the clock after a detected SCLK edge or chip-select edge.
- R9: Back-to-back frames are independent. Each one returns the words presented at its own chip-select fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Command data from the master |
| resp_a | input | 16 | Core A result word, captured at frame start |
| resp_b | input | 16 | Core B result word, captured at frame start |
| miso | output | 1 | Merged double-data-rate result line |
| cmd_word | output | 16 | Last complete command |
| cmd_valid | output | 1 | One-clock pulse when a good frame ends |
| frame_err | output | 1 | One-clock pulse when a frame has a wrong edge count |

## Verification
The hardest point to reach is the boundary where the frame ends. There, the sixteenth B bit must still be on MISO at the instant chip select rises, and one clock later the line must fall to zero. The bench gets there by letting a monitor sample MISO in the same time step that chip select goes high, before any clock edge can act on it. Other frames are cut short or run long to test the edge-count check. In some frames the parallel response inputs are inverted in the middle of the frame, which shows that only the words captured when chip select fell are sent.

// File: rtl/ddr_spi_slave.sv
module ddr_spi_slave #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         mosi,
  input  logic [W-1:0] resp_a,
  input  logic [W-1:0] resp_b,
  output logic         miso,
  output logic [W-1:0] cmd_word,
  output logic         cmd_valid,
  output logic         frame_err
);
  localparam int CW = $clog2(W + 2);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] CFULL = CW'(W);

  logic          cs_q, sclk_q, frame_on, sel_b;
  logic          a_bit, b_bit;
  logic [W-1:0]  sh_a, sh_b, cmd_sr;
  logic [CW-1:0] n_rise;

  wire cs_fall = cs_q & ~cs_n;
  wire cs_rise = ~cs_q & cs_n;
  wire in_frm  = ~cs_q & ~cs_n;
  wire s_rise  = in_frm & sclk & ~sclk_q;
  wire s_fall  = in_frm & ~sclk & sclk_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frame_on <= 1'b0;
      sel_b    <= 1'b0;
      a_bit    <= 1'b0;
      b_bit    <= 1'b0;
      sh_a     <= '0;
      sh_b     <= '0;
    end else if (cs_fall) begin
      frame_on <= 1'b1;
      sel_b    <= 1'b0;
      a_bit    <= 1'b0;
      sh_a     <= resp_a;
      sh_b     <= resp_b;
    end else if (cs_rise) begin
      frame_on <= 1'b0;
    end else if (s_rise) begin
      a_bit <= sh_a[W-1];
      sh_a  <= {sh_a[W-2:0], 1'b0};
      sel_b <= 1'b0;
    end else if (s_fall) begin
      b_bit <= sh_b[W-1];
      sh_b  <= {sh_b[W-2:0], 1'b0};
      sel_b <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_sr <= '0;
      n_rise <= '0;
    end else if (cs_fall) begin
      n_rise <= '0;
    end else if (s_rise) begin
      cmd_sr <= {cmd_sr[W-2:0], mosi};
      if (n_rise != CMAX) n_rise <= n_rise + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_word  <= '0;
      cmd_valid <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      cmd_valid <= cs_rise & (n_rise == CFULL);
      frame_err <= cs_rise & (n_rise != CFULL);
      if (cs_rise && n_rise == CFULL) cmd_word <= cmd_sr;
    end

  assign miso = frame_on & (sel_b ? b_bit : a_bit);
endmodule

// File: rtl/ddr_spi_slave_chk.sv
module ddr_spi_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic miso,
  input logic cmd_valid,
  input logic frame_err
);
  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) |-> !miso);
  // R2
  valid_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cs_n && $past(cs_n));
  // R6
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && frame_err));
  // R6
  err_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> cs_n);
  // R8
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n && $stable(cs_n) && $stable(sclk) |=> $stable(miso));
endmodule

bind ddr_spi_slave ddr_spi_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .miso(miso), .cmd_valid(cmd_valid), .frame_err(frame_err)
);

// File: tb/tb_ddr_spi_slave.sv
module tb_ddr_spi_slave;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, mosi = 0;
  logic [15:0] resp_a = 0, resp_b = 0;
  logic miso, cmd_valid, frame_err;
  logic [15:0] cmd_word;
  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [15:0] cmd, a, b; int nr; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  ddr_spi_slave dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .resp_a(resp_a), .resp_b(resp_b), .miso(miso), .cmd_word(cmd_word),
    .cmd_valid(cmd_valid), .frame_err(frame_err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic frame(input logic [15:0] cmd, a, b, input int nr, input bit scramble);
    exp_t e;
    e.cmd = cmd; e.a = a; e.b = b; e.nr = nr;
    q.push_back(e);
    @(negedge clk); resp_a = a; resp_b = b;
    @(negedge clk); cs_n = 0;
    repeat (2) @(negedge clk);
    if (scramble) begin resp_a = ~a; resp_b = ~b; end
    for (int i = 0; i < nr; i++) begin
      mosi = (i < 16) ? cmd[15-i] : 1'b0;
      repeat (2) @(negedge clk); sclk = 1;
      repeat (3) @(negedge clk); sclk = 0;
      repeat (3) @(negedge clk);
    end
    cs_n = 1;
    repeat (3) @(negedge clk);
    chk(miso == 1'b0, "R1 idle miso", miso, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      logic [15:0] ra, rb, prev_cmd;
      int nr, nf;
      exp_t e;
      @(negedge cs_n);
      ra = 0; rb = 0; nr = 0; nf = 0; prev_cmd = cmd_word;
      forever begin
        @(posedge sclk or negedge sclk or posedge cs_n);
        if (cs_n) break;
        if (sclk) begin
          nr++;
          if (nr >= 2 && nr <= 16) rb[17-nr] = miso;
        end else begin
          nf++;
          if (nf <= 16) ra[16-nf] = miso;
        end
      end
      rb[0] = miso;
      @(posedge clk); #1;
      e = q.pop_front();
      if (e.nr == 16) begin
        chk(ra == e.a, "R3 A stream", ra, e.a);
        chk(rb == e.b, "R4 B stream", rb, e.b);
        chk(cmd_word == e.cmd, "R2 cmd_word", cmd_word, e.cmd);
        chk(cmd_valid && !frame_err, "R2 cmd_valid", {cmd_valid, frame_err}, 2'b10);
      end else begin
        chk(frame_err && !cmd_valid, "R6 frame_err", {cmd_valid, frame_err}, 2'b01);
        chk(cmd_word == prev_cmd, "R6 cmd kept", cmd_word, prev_cmd);
      end
      @(posedge clk); #1;
      chk(!cmd_valid && !frame_err, "R2 single pulse", {cmd_valid, frame_err}, 0);
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk(miso == 0 && cmd_valid == 0 && frame_err == 0, "R7 reset outputs", {miso, cmd_valid, frame_err}, 0);
    chk(cmd_word == 0, "R7 reset cmd", cmd_word, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    frame(16'hA53C, 16'h8001, 16'h7FFE, 16, 0);
    frame(16'h0000, 16'hFFFF, 16'h0000, 16, 0);
    frame(16'hFFFF, 16'h0000, 16'hFFFF, 16, 0);
    // R5: inputs scrambled mid-frame
    frame(16'h1234, 16'hC0DE, 16'hBEEF, 16, 1);
    // R6: short and long frames
    frame(16'hDEAD, 16'h1111, 16'h2222, 10, 0);
    frame(16'h5555, 16'h3333, 16'h4444, 18, 0);
    frame(16'h0F0F, 16'h0000, 16'h0000, 0, 0);
    // R9: back-to-back distinct words
    frame(16'h8000, 16'h0001, 16'h8000, 16, 0);
    frame(16'h0001, 16'hAAAA, 16'h5555, 16, 1);
    frame(16'h3C3C, 16'h0035, 16'h003A, 16, 0);
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R9 all frames seen", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule